// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts a stream of 128-bit blocks with AES-128. All ten rounds are laid out in hardware one after another. Each round is cut into four register stages: byte substitution, row rotation, column mixing and round-key addition. The pipe is therefore 40 registers deep, and it accepts a new block on every clock cycle. An idle cycle on the input costs one output slot and nothing more.

The eleven round keys are expanded elsewhere, for example by software or by a slower engine. They arrive together on one wide bus and must stay steady while blocks that use them are in flight. A valid flag travels beside each block. The data registers load only when a valid block reaches them, so the output word stays steady between results. Byte substitution reads a constant 256-entry table. The package builds this table at elaboration from the field inverse and the affine map.

Top module: `aes128_pipe_enc`

## Requirements
- R1: `outValid` goes high exactly 40 cycles after the cycle in which `inValid` was high and reset was low. `outValid` is never high otherwise.
- R2: Each result equals AES-128 encryption of its input block under the supplied round keys. Key 0 is XORed in before the first round, and the tenth round skips the column mix. The plaintext 00112233445566778899aabbccddeeff under the key schedule of key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: One block is accepted on every cycle. A run of back-to-back inputs leaves the block as a back-to-back run of results, in the order they entered.
- R4: Idle input cycles reappear as idle output cycles with the same spacing. Every valid block still comes out with its own correct result.
- R5: `rst` is synchronous and active high. In a cycle with `rst` high, the input is dropped and every block in flight is discarded. `outValid` is low from the next cycle on until a block accepted after reset reaches the end.
- R6: Round key r occupies `roundKeys[128*r+127 : 128*r]`. Slot 0 is the initial key and slot 10 is the key of the last round. Each slot is used only for its own round.
- R7: While `outValid` is low, `outBlock` keeps the last result that was output.
- R8: State byte i (i = 4*column + row) sits in bits `127-8*i` down to `120-8*i` of `inBlock` and `outBlock`. The first byte is in the top eight bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| inValid | input | 1 | A block is presented this cycle |
| inBlock | input | 128 | Plaintext block |
| roundKeys | input | 1408 | Eleven round keys, key r in bits 128*r and up |
| outValid | output | 1 | A ciphertext block is presented this cycle |
| outBlock | output | 128 | Ciphertext block |

## Verification
The bench runs the published single-block vector against a literal ciphertext. A wrong byte order, a wrong S-box entry or a misplaced column mix all break that comparison. A long back-to-back run of counter-derived blocks shows that stages do not mix up neighbouring blocks. A gapped stream that includes the all-zero and all-ones blocks runs under unrelated per-round keys, so a swapped or reused key slot cannot match the bench's model. A reset applied in the middle of a stream shows that blocks in flight are dropped and that the output word holds its last value.

// File: rtl/aes128_pipe_pkg.sv
package aes128_pipe_pkg;

  localparam int NUM_ROUNDS       = 10;
  localparam int STAGES_PER_ROUND = 4;
  localparam int PIPE_DEPTH       = NUM_ROUNDS * STAGES_PER_ROUND;
  localparam int BLOCK_W          = 128;
  localparam int NUM_BYTES        = BLOCK_W / 8;
  localparam int KEY_BUS_W        = (NUM_ROUNDS + 1) * BLOCK_W;

  // element 0 is the most significant byte
  typedef logic [0:NUM_BYTES-1][7:0] aesState_t;
  typedef logic [255:0][7:0] sboxTbl_t;

  // strobes from control to datapath: one load enable per register stage
  typedef struct packed {
    logic [PIPE_DEPTH-1:0] stageLoad;
  } pipeStrobe_t;

  function automatic logic [7:0] gfDouble(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] cur;
    acc = 8'h00;
    cur = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ cur;
      cur = gfDouble(cur);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] acc;
    logic [7:0] sq;
    logic [7:0] expo;
    acc  = 8'h01;
    sq   = a;
    expo = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (expo[k]) acc = gfMul(acc, sq);
      sq = gfMul(sq, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affineMap(input logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic sboxTbl_t buildSbox();
    sboxTbl_t tbl;
    for (int i = 0; i < 256; i++) tbl[i] = affineMap(gfInv(8'(i)));
    return tbl;
  endfunction

  localparam sboxTbl_t SBOX_TBL = buildSbox();

  function automatic aesState_t subBytes(input aesState_t s);
    aesState_t o;
    for (int i = 0; i < NUM_BYTES; i++) o[i] = SBOX_TBL[s[i]];
    return o;
  endfunction

  // byte index = 4*column + row; row r rotates left by r columns
  function automatic aesState_t shiftRows(input aesState_t s);
    aesState_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[c*4 + r] = s[((c + r) % 4)*4 + r];
    return o;
  endfunction

  function automatic aesState_t mixColumns(input aesState_t s);
    aesState_t o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[c*4];
      a1 = s[c*4 + 1];
      a2 = s[c*4 + 2];
      a3 = s[c*4 + 3];
      o[c*4]     = gfDouble(a0) ^ gfDouble(a1) ^ a1 ^ a2 ^ a3;
      o[c*4 + 1] = a0 ^ gfDouble(a1) ^ gfDouble(a2) ^ a2 ^ a3;
      o[c*4 + 2] = a0 ^ a1 ^ gfDouble(a2) ^ gfDouble(a3) ^ a3;
      o[c*4 + 3] = gfDouble(a0) ^ a0 ^ a1 ^ a2 ^ gfDouble(a3);
    end
    return o;
  endfunction

endpackage

// File: rtl/aes128_pipe_ctrl.sv
module aes128_pipe_ctrl
  import aes128_pipe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output pipeStrobe_t strobe,
  output logic        outValid
);

  logic [PIPE_DEPTH-1:0] validQ;
  logic [PIPE_DEPTH-1:0] validIn;

  // flag entering each stage this cycle
  assign validIn = {validQ[PIPE_DEPTH-2:0], inValid};

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else     validQ <= validIn;
  end

  // no data register moves during reset, so the output word holds (R7)
  always_comb begin
    strobe.stageLoad = rst ? '0 : validIn;
  end

  assign outValid = validQ[PIPE_DEPTH-1];

endmodule

// File: rtl/aes128_round_unit.sv
module aes128_round_unit
  import aes128_pipe_pkg::*;
#(
  parameter bit IS_FINAL = 1'b0
)(
  input  logic                        clk,
  input  logic [STAGES_PER_ROUND-1:0] load,
  input  aesState_t                   stateIn,
  input  logic [BLOCK_W-1:0]          roundKey,
  output aesState_t                   stateOut
);

  aesState_t subQ, rotQ, mixQ, keyQ;
  aesState_t mixNext;

  always_ff @(posedge clk) begin
    if (load[0]) subQ <= subBytes(stateIn);
    if (load[1]) rotQ <= shiftRows(subQ);
    if (load[2]) mixQ <= mixNext;
    if (load[3]) keyQ <= mixQ ^ roundKey;
  end

  generate
    if (IS_FINAL) begin : g_noMix
      assign mixNext = rotQ;
    end else begin : g_mix
      assign mixNext = mixColumns(rotQ);
    end
  endgenerate

  assign stateOut = keyQ;

endmodule

// File: rtl/aes128_pipe_datapath.sv
module aes128_pipe_datapath
  import aes128_pipe_pkg::*;
(
  input  logic                 clk,
  input  pipeStrobe_t          strobe,
  input  logic [BLOCK_W-1:0]   inBlock,
  input  logic [KEY_BUS_W-1:0] roundKeys,
  output logic [BLOCK_W-1:0]   outBlock
);

  aesState_t chain [NUM_ROUNDS+1];

  // initial key addition folds into the first substitution stage
  assign chain[0] = inBlock ^ roundKeys[0 +: BLOCK_W];

  generate
    for (genvar r = 0; r < NUM_ROUNDS; r++) begin : g_round
      aes128_round_unit #(
        .IS_FINAL (r == NUM_ROUNDS - 1)
      ) roundUnit (
        .clk      (clk),
        .load     (strobe.stageLoad[r*STAGES_PER_ROUND +: STAGES_PER_ROUND]),
        .stateIn  (chain[r]),
        .roundKey (roundKeys[(r+1)*BLOCK_W +: BLOCK_W]),
        .stateOut (chain[r+1])
      );
    end
  endgenerate

  assign outBlock = chain[NUM_ROUNDS];

endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
  import aes128_pipe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [BLOCK_W-1:0]   inBlock,
  input  logic [KEY_BUS_W-1:0] roundKeys,
  output logic                 outValid,
  output logic [BLOCK_W-1:0]   outBlock
);

  pipeStrobe_t strobe;

  aes128_pipe_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  aes128_pipe_datapath dp_i (
    .clk       (clk),
    .strobe    (strobe),
    .inBlock   (inBlock),
    .roundKeys (roundKeys),
    .outBlock  (outBlock)
  );

endmodule

// File: rtl/aes128_pipe_enc_chk.sv
module aes128_pipe_enc_chk
  import aes128_pipe_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               outValid,
  input logic [BLOCK_W-1:0] outBlock
);

  localparam int CNT_W = $clog2(PIPE_DEPTH + 1) + 1;

  logic [PIPE_DEPTH-1:0] modelValid;
  logic [CNT_W-1:0]      inFlight;

  always_ff @(posedge clk) begin
    if (rst) begin
      modelValid <= '0;
      inFlight   <= '0;
    end else begin
      modelValid <= {modelValid[PIPE_DEPTH-2:0], inValid};
      inFlight   <= inFlight + CNT_W'(inValid) - CNT_W'(outValid);
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid == modelValid[PIPE_DEPTH-1]); // R1

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CNT_W'(PIPE_DEPTH)); // R3

  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !outValid); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outBlock)); // R7

endmodule

bind aes128_pipe_enc aes128_pipe_enc_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outBlock (outBlock)
);

// File: tb/aes128_pipe_enc_tb.sv
module aes128_pipe_enc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 40;
  localparam int SLOTS      = 512;

  logic              clk = 1'b0;
  logic              rst;
  logic              inValid;
  logic [127:0]      inBlock;
  logic [10:0][127:0] roundKeys;
  logic              outValid;
  logic [127:0]      outBlock;

  aes128_pipe_enc dut_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inBlock   (inBlock),
    .roundKeys (roundKeys),
    .outValid  (outValid),
    .outBlock  (outBlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  string curTag = "R5";
  bit          expValid [SLOTS];
  logic [127:0] expData [SLOTS];
  logic [127:0] lastOut;
  bit           seenOut = 0;
  logic [7:0]   sb [256];

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box from the generator-3 walk with an incremental inverse
  task automatic buildSbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
      sb[p] = x;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] model(input logic [127:0] pt, input logic [10:0][127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] blk;
    blk = pt ^ k[0];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[blk[127-8*i -: 8]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[c*4+w] = s[((c+w)%4)*4+w];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = t[c*4]; a1 = t[c*4+1]; a2 = t[c*4+2]; a3 = t[c*4+3];
          t[c*4]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          t[c*4+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          t[c*4+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          t[c*4+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = t[i];
      blk = blk ^ k[r];
    end
    return blk;
  endfunction

  function automatic logic [10:0][127:0] expandKey(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc;
    logic [10:0][127:0] ks;
    rc = 8'h01;
    for (int i = 0; i < 44; i++) begin
      if (i < 4) w[i] = key[127-32*i -: 32];
      else begin
        tmp = w[i-1];
        if (i % 4 == 0) begin
          tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
          rc = xt(rc);
        end
        w[i] = w[i-4] ^ tmp;
      end
    end
    for (int r = 0; r <= 10; r++) ks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return ks;
  endfunction

  task automatic checkNow();
    checks++;
    if (outValid !== expValid[cyc]) begin
      errors++;
      $display("FAIL %s cycle %0d outValid actual=%b expected=%b", curTag, cyc, outValid, expValid[cyc]);
    end
    if (expValid[cyc]) begin
      checks++;
      if (outBlock !== expData[cyc]) begin
        errors++;
        $display("FAIL %s cycle %0d outBlock actual=%h expected=%h", curTag, cyc, outBlock, expData[cyc]);
      end
      lastOut = expData[cyc];
      seenOut = 1;
    end else if (seenOut) begin
      checks++;
      if (outBlock !== lastOut) begin
        errors++;
        $display("FAIL R7 cycle %0d idle outBlock actual=%h expected=%h", cyc, outBlock, lastOut);
      end
    end
  endtask

  // one cycle: check what is visible now, then drive the next input
  task automatic step(input bit v, input logic [127:0] pt, input bit r);
    @(negedge clk);
    checkNow();
    rst = r; inValid = v; inBlock = pt;
    if (r) begin
      for (int j = 1; j <= LAT; j++) expValid[cyc+j] = 1'b0;
    end else if (v) begin
      expValid[cyc+LAT] = 1'b1;
      expData[cyc+LAT]  = model(pt, roundKeys);
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 128'h0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [127:0] fipsCt;
    logic [10:0][127:0] altKeys;
    for (int i = 0; i < SLOTS; i++) begin expValid[i] = 1'b0; expData[i] = '0; end
    buildSbox();
    rst = 1'b1; inValid = 1'b0; inBlock = '0;
    roundKeys = expandKey(128'h000102030405060708090a0b0c0d0e0f);

    // R5: reset state
    curTag = "R5";
    for (int i = 0; i < 3; i++) step(1'b0, 128'h0, 1'b1);

    // R2 R8: published vector checked against a literal
    curTag = "R1 R2 R8";
    fipsCt = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    checks++;
    if (model(128'h00112233445566778899aabbccddeeff, roundKeys) !== fipsCt) begin
      errors++;
      $display("FAIL R2 bench model actual=%h expected=%h",
               model(128'h00112233445566778899aabbccddeeff, roundKeys), fipsCt);
    end
    step(1'b1, 128'h00112233445566778899aabbccddeeff, 1'b0);
    expData[cyc-1+LAT] = fipsCt;
    idle(45);

    // R3: back-to-back stream
    curTag = "R3";
    for (int k = 0; k < 48; k++)
      step(1'b1, {32'(k) * 32'h9e3779b9, ~32'(k), 32'(k) << 5, 32'hc0de0000 + 32'(k)}, 1'b0);
    idle(42);

    // R4 R6: gapped stream under unrelated per-slot keys
    curTag = "R4 R6";
    for (int r = 0; r <= 10; r++)
      altKeys[r] = {4{32'(r + 1) * 32'h01234567}} ^ {32'(r) << 27, 96'h5a5a_a5a5_0f0f_f0f0_3c3c_c3c3};
    roundKeys = altKeys;
    for (int k = 0; k < 30; k++) begin
      if (k % 3 == 2)   step(1'b0, 128'h0, 1'b0);
      else if (k == 0)  step(1'b1, 128'h0, 1'b0);
      else if (k == 1)  step(1'b1, {128{1'b1}}, 1'b0);
      else              step(1'b1, {4{32'(k) * 32'h7f4a7c15}}, 1'b0);
    end
    idle(42);

    // R5: reset in the middle of a stream
    curTag = "R5";
    roundKeys = expandKey(128'h2b7e151628aed2a6abf7158809cf4f3c);
    for (int k = 0; k < 20; k++)
      step(1'b1, {96'h0, 32'(k)} ^ 128'h3243f6a8885a308d313198a2e0370734, (k == 12));
    for (int k = 0; k < 10; k++)
      step(1'b1, {32'(k), 96'hfeedface_0badf00d_12345678}, 1'b0);
    idle(42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule